// File: doc/BRIEF.md
# Edge-Capture Interval Timer

This block is an 8-bit up-counter peripheral with two modes. It advances once on each cycle in which the selected prescaled clock enable is high. In interval mode the counter simply free-runs. A wrap from 0xFF to 0x00 can raise a sticky overflow flag. In capture mode, edges on an external capture pin copy the running count into one of two read-only registers. Rising edges go to one register and falling edges to the other. The counter can also be zeroed on rising edges, on falling edges or on both.

Software reaches the block through a small synchronous register bus. One control register and the two capture registers are visible on it. The counter itself cannot be reached from the bus. The prescaler that produces the clock enables, the interrupt controller and the pin multiplexing sit outside the block. The overflow flag is cleared by a pulse on a dedicated input. It is forwarded as an interrupt request only while an external enable input is high.

Top module: `cap_tmr8`

## Requirements
- R1: While reset is low, and right after it, the control register, the counter, both capture registers and the overflow flag all hold 0. Reads at addresses 0, 1, 2 and 3 return 0x00, and the overflow flag output is low.
- R2: The control register sits at address 0 and is written when bus_wr is high at a clock edge. Its fields are:
  - bits 1:0 select the clock enable;
  - bits 3:2 select the clear edge;
  - bit 4 selects capture mode when set and interval mode when cleared;
  - bit 5 enables overflow flagging.

  Bits 7:6 always read 0.
- R3: The counter grows by one at each clock edge where tick_en[clock select] is high, and it wraps from 0xFF to 0x00. It holds its value when that enable is low.
- R4: cap_in passes through two synchronising flip-flops. Edge detection then compares the newest synchronised sample with the one before it. A level change that is first sampled at clock edge k takes effect at edge k+2.
- R5: In capture mode, a rising edge loads the count held just before that clock edge into the rising-capture register, which reads at address 2.
- R6: In capture mode, a falling edge loads the count held just before that clock edge into the falling-capture register, which reads at address 1.
- R7: In capture mode, the clear-select field controls which edges zero the counter. The codes are 00 never, 01 falling, 10 rising and 11 both. A clear takes priority over a tick in the same cycle. A capture on the same edge still receives the count from before the clear.
- R8: The overflow flag is set when a tick wraps the counter from 0xFF while bit 5 is 1. An edge-driven clear is not a wrap. The flag stays set until flag_clr is high at a clock edge. A wrap in the same cycle as flag_clr leaves the flag set.
- R9: ovf_irq is high exactly when the overflow flag is set and irq_en is high.
- R10: In interval mode, capture-pin edges neither load the capture registers nor clear the counter. Toggling the mode bit while cap_in is steady produces no capture.
- R11: Writes to addresses 1, 2 and 3 change no register. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| tick_en | input | 4 | Prescaled clock enables, one per select code |
| cap_in | input | 1 | Asynchronous capture pin |
| irq_en | input | 1 | Interrupt forwarding enable |
| flag_clr | input | 1 | Overflow flag clear pulse |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The timer is first run with the enable always high, which makes the wrap and the overflow timing exact. It is then run with random enable patterns on each select code, which shows whether the correct enable is picked. Capture-pin toggles at dense and sparse rates, under each of the four clear codes, show whether the rising and falling paths are separate, whether the pre-clear value is captured, and whether the clear beats the tick. Sparse toggles with a long hold let the counter wrap between clears, which shows that a clear is not counted as an overflow. A steady pin under mode flips, and toggles in interval mode, show that no spurious capture occurs. Random flag_clr pulses during wraps exercise the case where a set and a clear land in the same cycle.

// File: rtl/cap_tmr8_pkg.sv
package cap_tmr8_pkg;

    localparam int CLK_SEL_W = 2;
    localparam int NUM_CLK   = 1 << CLK_SEL_W;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CAPF = 2'd1;
    localparam logic [1:0] A_CAPR = 2'd2;

    // clear-select codes: bit 1 = rising, bit 0 = falling
    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_FALL = 2'b01,
        CLR_RISE = 2'b10,
        CLR_BOTH = 2'b11
    } clr_sel_e;

    typedef struct packed {
        logic [1:0]           rsvd;
        logic                 ovf_en;
        logic                 cap_mode;
        clr_sel_e             clr_sel;
        logic [CLK_SEL_W-1:0] clk_sel;
    } ctrl_t;

endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], pin_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o =  sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
    assign fall_o = ~sh_q[SYNC_STAGES-1] &  sh_q[SYNC_STAGES];

    // R4
    sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> $past(pin_i, 2));

endmodule

// File: rtl/cap_tmr8_core.sv
module cap_tmr8_core #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          cap_mode_i,
    input  logic [1:0]    clr_sel_i,
    input  logic          ovf_en_i,
    input  logic          rise_i,
    input  logic          fall_i,
    input  logic          flag_clr_i,
    output logic [DW-1:0] cap_rise_o,
    output logic [DW-1:0] cap_fall_o,
    output logic          flag_o
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] cap_r;
        logic [DW-1:0] cap_f;
        logic          flag;
    } st_t;

    st_t  st_d, st_q;
    logic clr;
    logic wrap;

    always_comb begin
        st_d = st_q;
        clr  = cap_mode_i && ((rise_i && clr_sel_i[1]) || (fall_i && clr_sel_i[0]));
        wrap = tick_i && (st_q.cnt == '1) && !clr;
        if (clr)         st_d.cnt = '0;
        else if (tick_i) st_d.cnt = st_q.cnt + DW'(1);
        if (cap_mode_i && rise_i) st_d.cap_r = st_q.cnt;
        if (cap_mode_i && fall_i) st_d.cap_f = st_q.cnt;
        if (wrap && ovf_en_i)     st_d.flag  = 1'b1;
        else if (flag_clr_i)      st_d.flag  = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_rise_o = st_q.cap_r;
    assign cap_fall_o = st_q.cap_f;
    assign flag_o     = st_q.flag;

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr) |=> st_q.cnt == DW'($past(st_q.cnt) + 1'b1));

    // R7
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> st_q.cnt == '0);

    // R5
    cap_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode_i && rise_i) |=> cap_rise_o == $past(st_q.cnt));

    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_en_i && tick_i && st_q.cnt == '1 && !clr) |=> flag_o);

    // R8
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr_i) |=> flag_o);

endmodule

// File: rtl/cap_tmr8.sv
module cap_tmr8
    import cap_tmr8_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [1:0]         bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [NUM_CLK-1:0] tick_en,
    input  logic               cap_in,
    input  logic               irq_en,
    input  logic               flag_clr,
    output logic               ovf_flag,
    output logic               ovf_irq
);
    ctrl_t         ctrl_d, ctrl_q;
    logic          rise, fall, tick;
    logic [DW-1:0] cap_r, cap_f;

    always_comb begin
        ctrl_d = ctrl_q;
        if (bus_wr && bus_addr == A_CTRL) begin
            ctrl_d      = ctrl_t'(bus_wdata[7:0]);
            ctrl_d.rsvd = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign tick = tick_en[ctrl_q.clk_sel];

    cap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (cap_in),
        .rise_o (rise),
        .fall_o (fall)
    );

    cap_tmr8_core #(.DW(DW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .cap_mode_i (ctrl_q.cap_mode),
        .clr_sel_i  (ctrl_q.clr_sel),
        .ovf_en_i   (ctrl_q.ovf_en),
        .rise_i     (rise),
        .fall_i     (fall),
        .flag_clr_i (flag_clr),
        .cap_rise_o (cap_r),
        .cap_fall_o (cap_f),
        .flag_o     (ovf_flag)
    );

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = DW'(ctrl_q);
            A_CAPF:  bus_rdata = cap_f;
            A_CAPR:  bus_rdata = cap_r;
            default: bus_rdata = '0;
        endcase
    end

    assign ovf_irq = ovf_flag & irq_en;

    // R10
    interval_nocap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.cap_mode |=> ($stable(cap_r) && $stable(cap_f)));

    // R11
    ctrl_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != A_CTRL) |=> $stable(ctrl_q));

endmodule

// File: tb/tb_cap_tmr8.sv
module tb_cap_tmr8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [3:0] tick_en = 4'd0;
    logic       cap_in = 1'b0;
    logic       irq_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       ovf_flag, ovf_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int m_ctrl = 0, m_cnt = 0, m_cf = 0, m_cr = 0, m_flag = 0;
    int s1 = 0, s2 = 0, pv = 0;

    always #5 clk = ~clk;

    cap_tmr8 dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
        .cap_in(cap_in), .irq_en(irq_en), .flag_clr(flag_clr),
        .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_cnt = 0; m_cf = 0; m_cr = 0; m_flag = 0;
            s1 = 0; s2 = 0; pv = 0;
        end else begin
            int sel, cs, md, oe, er, ef, clr, tk, wr;
            sel = m_ctrl & 3;
            cs  = (m_ctrl >> 2) & 3;
            md  = (m_ctrl >> 4) & 1;
            oe  = (m_ctrl >> 5) & 1;
            er  = md && s2 && !pv;
            ef  = md && !s2 && pv;
            clr = (er && (cs & 2)) || (ef && (cs & 1));
            tk  = tick_en[sel];
            wr  = tk && (m_cnt == 255) && !clr;
            if (er) m_cr = m_cnt;
            if (ef) m_cf = m_cnt;
            if (clr)     m_cnt = 0;
            else if (tk) m_cnt = (m_cnt + 1) & 255;
            if (wr && oe)      m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (bus_wr && bus_addr == 2'd0) m_ctrl = bus_wdata & 8'h3F;
            pv = s2; s2 = s1; s1 = cap_in;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        int exp_rd;
        check("R8 ovf_flag", ovf_flag, m_flag);
        check("R9 ovf_irq", ovf_irq, m_flag && irq_en);
        case (bus_addr)
            2'd0: begin exp_rd = m_ctrl; check("R2 ctrl read", bus_rdata, exp_rd); end
            2'd1: begin exp_rd = m_cf;   check("R6 fall capture", bus_rdata, exp_rd); end
            2'd2: begin exp_rd = m_cr;   check("R5 rise capture", bus_rdata, exp_rd); end
            default: check("R11 addr3 read", bus_rdata, 0);
        endcase
    endtask

    task automatic tick_n(input int n);
        repeat (n) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] v);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        tick_n(1);
        bus_wr = 1'b0;
    endtask

    // tick_mode 0: all enables high, else random; tog_div 0: no toggling
    task automatic run(input int n, input int tick_mode, input int tog_div, input bit rnd_clr);
        for (int i = 0; i < n; i++) begin
            bus_addr = 2'($urandom % 4);
            tick_en  = (tick_mode == 0) ? 4'hF : 4'($urandom);
            if (tog_div != 0 && ($urandom % tog_div) == 0) cap_in = ~cap_in;
            flag_clr = rnd_clr ? (($urandom % 8) == 0) : 1'b0;
            irq_en   = 1'($urandom);
            tick_n(1);
        end
        flag_clr = 1'b0;
    endtask

    initial begin
        int v0;
        repeat (3) @(negedge clk);
        for (int a = 0; a < 4; a++) begin
            bus_addr = 2'(a); #1;
            check("R1 reset read", bus_rdata, 0);
        end
        check("R1 reset flag", ovf_flag, 0);
        rst_n = 1'b1;
        tick_n(2);

        // R2 reserved bits read as zero
        wr_reg(2'd0, 8'hFF);
        bus_addr = 2'd0; #1;
        check("R2 rsvd bits", bus_rdata, 8'h3F);

        // R3 / R8: interval mode, always ticking, overflow enabled
        wr_reg(2'd0, 8'h20);
        tick_en = 4'hF; irq_en = 1'b1;
        tick_n(300);
        check("R8 flag after wrap", ovf_flag, 1);
        check("R9 irq forwarded", ovf_irq, 1);
        flag_clr = 1'b1; tick_n(1); flag_clr = 1'b0;
        check("R8 flag cleared", ovf_flag, 0);

        // R3 clock select variants with random enables
        for (int s = 0; s < 4; s++) begin
            wr_reg(2'd0, 8'(8'h20 | s));
            run(400, 1, 0, 1'b1);
        end

        // R4 latency of the synchroniser
        wr_reg(2'd0, 8'h10);
        tick_en = 4'hF; cap_in = 1'b0; bus_addr = 2'd2;
        tick_n(6);
        v0 = bus_rdata;
        cap_in = 1'b1;
        tick_n(2);
        check("R4 no capture before third edge", bus_rdata, v0);
        tick_n(1);
        check("R4 capture at third edge", bus_rdata, m_cr);

        // R5 / R6 capture without clear, dense and sparse toggles
        run(400, 0, 3, 1'b0);
        run(400, 1, 11, 1'b0);

        // R7 clear-select codes, with overflow enabled
        for (int c = 0; c < 4; c++) begin
            wr_reg(2'd0, 8'(8'h30 | (c << 2)));
            run(300, 0, 4, 1'b1);
            run(900, 0, 300, 1'b1);
        end

        // R10 interval mode ignores toggles
        wr_reg(2'd0, 8'h2C);
        run(300, 0, 3, 1'b0);
        cap_in = 1'b1; tick_n(6);
        bus_addr = 2'd2; #1; v0 = bus_rdata;
        for (int k = 0; k < 4; k++) begin
            wr_reg(2'd0, 8'h1C); tick_n(3);
            wr_reg(2'd0, 8'h0C); tick_n(3);
        end
        bus_addr = 2'd2; #1;
        check("R10 mode flip no capture", bus_rdata, v0);

        // R11 writes to other addresses are ignored
        wr_reg(2'd0, 8'h15);
        wr_reg(2'd1, 8'hAA); wr_reg(2'd2, 8'h55); wr_reg(2'd3, 8'hFF);
        bus_addr = 2'd0; #1;
        check("R11 ctrl unchanged", bus_rdata, 8'h15);
        bus_addr = 2'd3; #1;
        check("R11 addr3 zero", bus_rdata, 0);
        run(200, 1, 5, 1'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule